// File: doc/BRIEF.md
# Inclusive Shared Cache Core-Valid Tracker

This block is the directory for an inclusive last-level cache shared by four cores. The shared cache holds a copy of every line that sits in any core's private caches. Each resident line keeps one presence bit per core, so a request only needs to probe the cores that may hold the line, and the other cores are left alone. Tags and presence bits live in a small direct-mapped array. Line data, the snoop transport and the path to main memory are handled elsewhere.

A core issues a lookup with a line address, its core number and a read or write flag. One cycle later the block reports hit or miss and gives the set of other cores to snoop. The cache controller uses the fill port to install lines and the same port, with a drop flag, to evict them. Removing a valid line produces a back-invalidate to every core that still holds it. Cores send eviction notices when they drop a line on their own, and the block clears their presence bit.

Top module: `cv_tracker`

## Requirements
- R1: While reset is asserted, and after it is released, every line is invalid and all outputs are low, so the first lookup to any address misses.
- R2: A lookup accepted at a clock edge presents `lkp_done_o`, `lkp_hit_o` and `lkp_snoop_o` for exactly the following cycle.
- R3: A lookup miss, read or write, reports hit=0 and an all-zero snoop mask, and allocates nothing: a repeated lookup to the same address misses again.
- R4: A read hit reports a snoop mask equal to the line's presence bits with the requester's bit cleared (bit i means core i), and then sets the requester's bit.
- R5: A write hit reports the same snoop mask as a read would, and afterwards leaves only the writer's bit set on the line.
- R6: A fill to an index with no valid line, or with a different tag, installs the line with only the filling core's bit set. A fill to an already resident line adds the filling core's bit and raises no back-invalidate.
- R7: A fill that replaces a valid line with a different tag raises `binv_valid_o` one cycle later, with the victim's line address and its full presence vector.
- R8: A drop request to a resident line raises a back-invalidate carrying that line's address and presence vector, and makes the line invalid. A drop to an absent address produces no output and changes nothing.
- R9: A core eviction notice clears only that core's bit on a resident matching line. A notice for an absent line has no effect, and neither case produces an output.
- R10: At most one request is taken per cycle, with this priority: fill/drop first, then lookup, then core eviction notice. A request that loses arbitration is discarded, produces no output and changes no state.
- R11: The set index is the low log2(SETS) bits of the line address, and the remaining bits form the tag. Two addresses with the same index and different tags displace each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lkp_valid_i | input | 1 | Lookup request |
| lkp_write_i | input | 1 | 1 = write lookup, 0 = read lookup |
| lkp_addr_i | input | LINE_ADDR_W | Lookup line address |
| lkp_core_i | input | CID_W | Requesting core number |
| fill_valid_i | input | 1 | Fill or drop request |
| fill_drop_i | input | 1 | 1 = drop (evict) the line, 0 = fill it |
| fill_addr_i | input | LINE_ADDR_W | Fill/drop line address |
| fill_core_i | input | CID_W | Core receiving the filled line |
| cev_valid_i | input | 1 | Core eviction notice |
| cev_addr_i | input | LINE_ADDR_W | Line dropped by the core |
| cev_core_i | input | CID_W | Core that dropped the line |
| lkp_done_o | output | 1 | Lookup result valid |
| lkp_hit_o | output | 1 | Lookup hit |
| lkp_snoop_o | output | NUM_CORES | Cores to snoop |
| binv_valid_o | output | 1 | Back-invalidate issued |
| binv_addr_o | output | LINE_ADDR_W | Line address being invalidated |
| binv_mask_o | output | NUM_CORES | Cores that must invalidate the line |

## Verification
Lookups are run against presence vectors built up one core at a time. These include a single holder, several holders where the requester is one of them, and a full vector. A result that tracks the requester's own bit therefore looks different from one that ignores it. A write by one core followed by a read from another tells a vector that was reduced to the writer apart from one that was only extended. Eviction notices and drops are sent to absent addresses on an occupied index, which separates a tag compare from an index-only match. Requests from several ports in the same cycle are combined so that a wrong priority order shows up either as a missing output or as a later snoop mask that still carries a stale bit.

// File: rtl/cv_tracker_pkg.sv
package cv_tracker_pkg;
  typedef enum logic [2:0] {
    OP_IDLE,
    OP_RD,
    OP_WR,
    OP_FILL,
    OP_DROP,
    OP_CEV
  } cv_op_e;
endpackage

// File: rtl/cv_op_sel.sv
module cv_op_sel
  import cv_tracker_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int CID_W  = 2
) (
  input  logic              fill_valid_i,
  input  logic              fill_drop_i,
  input  logic [ADDR_W-1:0] fill_addr_i,
  input  logic [CID_W-1:0]  fill_core_i,
  input  logic              lkp_valid_i,
  input  logic              lkp_write_i,
  input  logic [ADDR_W-1:0] lkp_addr_i,
  input  logic [CID_W-1:0]  lkp_core_i,
  input  logic              cev_valid_i,
  input  logic [ADDR_W-1:0] cev_addr_i,
  input  logic [CID_W-1:0]  cev_core_i,
  output cv_op_e            op_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [CID_W-1:0]  core_o
);
  // fixed priority: fill/drop, lookup, core eviction
  always_comb begin
    op_o   = OP_IDLE;
    addr_o = '0;
    core_o = '0;
    if (fill_valid_i) begin
      op_o   = fill_drop_i ? OP_DROP : OP_FILL;
      addr_o = fill_addr_i;
      core_o = fill_core_i;
    end else if (lkp_valid_i) begin
      op_o   = lkp_write_i ? OP_WR : OP_RD;
      addr_o = lkp_addr_i;
      core_o = lkp_core_i;
    end else if (cev_valid_i) begin
      op_o   = OP_CEV;
      addr_o = cev_addr_i;
      core_o = cev_core_i;
    end
  end
endmodule

// File: rtl/cv_dir_array.sv
module cv_dir_array #(
  parameter int SETS  = 16,
  parameter int TAG_W = 8,
  parameter int NC    = 4,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             rd_valid_o,
  output logic [TAG_W-1:0] rd_tag_o,
  output logic [NC-1:0]    rd_vec_o,
  input  logic             we_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             wr_valid_i,
  input  logic [TAG_W-1:0] wr_tag_i,
  input  logic [NC-1:0]    wr_vec_i
);
  logic [SETS-1:0]            vld_all;
  logic [SETS-1:0][TAG_W-1:0] tag_all;
  logic [SETS-1:0][NC-1:0]    vec_all;

  for (genvar s = 0; s < SETS; s++) begin : g_set
    logic             vld_q;
    logic [TAG_W-1:0] tag_q;
    logic [NC-1:0]    vec_q;
    logic             sel;

    assign sel = we_i && (wr_idx_i == IDX_W'(s));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q <= 1'b0;
        tag_q <= '0;
        vec_q <= '0;
      end else if (sel) begin
        vld_q <= wr_valid_i;
        tag_q <= wr_tag_i;
        vec_q <= wr_vec_i;
      end
    end

    assign vld_all[s] = vld_q;
    assign tag_all[s] = tag_q;
    assign vec_all[s] = vec_q;
  end

  assign rd_valid_o = vld_all[rd_idx_i];
  assign rd_tag_o   = tag_all[rd_idx_i];
  assign rd_vec_o   = vec_all[rd_idx_i];

  AST_WRITE_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (vld_all[$past(wr_idx_i)] == $past(wr_valid_i)
              && vec_all[$past(wr_idx_i)] == $past(wr_vec_i))); // R6
endmodule

// File: rtl/cv_line_update.sv
module cv_line_update
  import cv_tracker_pkg::*;
#(
  parameter int NC    = 4,
  parameter int TAG_W = 8,
  parameter int CID_W = 2
) (
  input  cv_op_e           op_i,
  input  logic [CID_W-1:0] core_i,
  input  logic [TAG_W-1:0] tag_i,
  input  logic             line_valid_i,
  input  logic [TAG_W-1:0] line_tag_i,
  input  logic [NC-1:0]    line_vec_i,
  output logic             hit_o,
  output logic [NC-1:0]    snoop_o,
  output logic             we_o,
  output logic             new_valid_o,
  output logic [NC-1:0]    new_vec_o,
  output logic             binv_o,
  output logic [NC-1:0]    binv_mask_o
);
  logic          match;
  logic [NC-1:0] own;

  assign match = line_valid_i && (line_tag_i == tag_i);
  assign own   = NC'(1) << core_i;

  always_comb begin
    hit_o       = 1'b0;
    snoop_o     = '0;
    we_o        = 1'b0;
    new_valid_o = line_valid_i;
    new_vec_o   = line_vec_i;
    binv_o      = 1'b0;
    binv_mask_o = '0;
    unique case (op_i)
      OP_RD, OP_WR: begin
        hit_o = match;
        if (match) begin
          snoop_o     = line_vec_i & ~own;
          we_o        = 1'b1;
          new_valid_o = 1'b1;
          new_vec_o   = (op_i == OP_WR) ? own : (line_vec_i | own);
        end
      end
      OP_FILL: begin
        we_o        = 1'b1;
        new_valid_o = 1'b1;
        if (match) begin
          new_vec_o = line_vec_i | own;
        end else begin
          new_vec_o   = own;
          binv_o      = line_valid_i;
          binv_mask_o = line_valid_i ? line_vec_i : '0;
        end
      end
      OP_DROP: begin
        if (match) begin
          we_o        = 1'b1;
          new_valid_o = 1'b0;
          new_vec_o   = '0;
          binv_o      = 1'b1;
          binv_mask_o = line_vec_i;
        end
      end
      OP_CEV: begin
        if (match) begin
          we_o        = 1'b1;
          new_valid_o = 1'b1;
          new_vec_o   = line_vec_i & ~own;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/cv_tracker.sv
module cv_tracker
  import cv_tracker_pkg::*;
#(
  parameter int NUM_CORES   = 4,
  parameter int LINE_ADDR_W = 12,
  parameter int SETS        = 16,
  localparam int CID_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   lkp_valid_i,
  input  logic                   lkp_write_i,
  input  logic [LINE_ADDR_W-1:0] lkp_addr_i,
  input  logic [CID_W-1:0]       lkp_core_i,
  input  logic                   fill_valid_i,
  input  logic                   fill_drop_i,
  input  logic [LINE_ADDR_W-1:0] fill_addr_i,
  input  logic [CID_W-1:0]       fill_core_i,
  input  logic                   cev_valid_i,
  input  logic [LINE_ADDR_W-1:0] cev_addr_i,
  input  logic [CID_W-1:0]       cev_core_i,
  output logic                   lkp_done_o,
  output logic                   lkp_hit_o,
  output logic [NUM_CORES-1:0]   lkp_snoop_o,
  output logic                   binv_valid_o,
  output logic [LINE_ADDR_W-1:0] binv_addr_o,
  output logic [NUM_CORES-1:0]   binv_mask_o
);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = LINE_ADDR_W - IDX_W;

  cv_op_e                 op;
  logic [LINE_ADDR_W-1:0] op_addr;
  logic [CID_W-1:0]       op_core;
  logic [IDX_W-1:0]       op_idx;
  logic [TAG_W-1:0]       op_tag;

  logic                   line_valid;
  logic [TAG_W-1:0]       line_tag;
  logic [NUM_CORES-1:0]   line_vec;

  logic                   hit, we, new_valid, binv;
  logic [NUM_CORES-1:0]   snoop, new_vec, binv_mask;
  logic                   is_lkp;

  cv_op_sel #(.ADDR_W(LINE_ADDR_W), .CID_W(CID_W)) u_sel (
    .fill_valid_i (fill_valid_i),
    .fill_drop_i  (fill_drop_i),
    .fill_addr_i  (fill_addr_i),
    .fill_core_i  (fill_core_i),
    .lkp_valid_i  (lkp_valid_i),
    .lkp_write_i  (lkp_write_i),
    .lkp_addr_i   (lkp_addr_i),
    .lkp_core_i   (lkp_core_i),
    .cev_valid_i  (cev_valid_i),
    .cev_addr_i   (cev_addr_i),
    .cev_core_i   (cev_core_i),
    .op_o         (op),
    .addr_o       (op_addr),
    .core_o       (op_core)
  );

  assign op_idx = op_addr[IDX_W-1:0];
  assign op_tag = op_addr[LINE_ADDR_W-1:IDX_W];
  assign is_lkp = (op == OP_RD) || (op == OP_WR);

  cv_dir_array #(.SETS(SETS), .TAG_W(TAG_W), .NC(NUM_CORES)) u_dir (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_idx_i   (op_idx),
    .rd_valid_o (line_valid),
    .rd_tag_o   (line_tag),
    .rd_vec_o   (line_vec),
    .we_i       (we),
    .wr_idx_i   (op_idx),
    .wr_valid_i (new_valid),
    .wr_tag_i   (op_tag),
    .wr_vec_i   (new_vec)
  );

  cv_line_update #(.NC(NUM_CORES), .TAG_W(TAG_W), .CID_W(CID_W)) u_upd (
    .op_i         (op),
    .core_i       (op_core),
    .tag_i        (op_tag),
    .line_valid_i (line_valid),
    .line_tag_i   (line_tag),
    .line_vec_i   (line_vec),
    .hit_o        (hit),
    .snoop_o      (snoop),
    .we_o         (we),
    .new_valid_o  (new_valid),
    .new_vec_o    (new_vec),
    .binv_o       (binv),
    .binv_mask_o  (binv_mask)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lkp_done_o   <= 1'b0;
      lkp_hit_o    <= 1'b0;
      lkp_snoop_o  <= '0;
      binv_valid_o <= 1'b0;
      binv_addr_o  <= '0;
      binv_mask_o  <= '0;
    end else begin
      lkp_done_o   <= is_lkp;
      lkp_hit_o    <= is_lkp && hit;
      lkp_snoop_o  <= is_lkp ? snoop : '0;
      binv_valid_o <= binv;
      binv_addr_o  <= binv ? {line_tag, op_idx} : '0;
      binv_mask_o  <= binv ? binv_mask : '0;
    end
  end

  AST_LKP_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lkp_valid_i && !fill_valid_i) |=> lkp_done_o); // R2
  AST_MISS_NO_SNOOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lkp_done_o && !lkp_hit_o) |-> (lkp_snoop_o == '0)); // R3
  AST_REQ_NOT_SNOOPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lkp_valid_i && !fill_valid_i) |=>
      ((lkp_snoop_o & (NUM_CORES'(1) << $past(lkp_core_i))) == '0)); // R4
  AST_FILL_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_valid_i |=> !lkp_done_o); // R10
  AST_SINGLE_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(lkp_done_o && binv_valid_o)); // R10
  AST_BINV_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    binv_valid_o |-> $past(fill_valid_i)); // R7
endmodule

// File: tb/cv_tracker_tb_top.sv
module cv_tracker_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni;
  logic        lkp_valid_i, lkp_write_i;
  logic [11:0] lkp_addr_i;
  logic [1:0]  lkp_core_i;
  logic        fill_valid_i, fill_drop_i;
  logic [11:0] fill_addr_i;
  logic [1:0]  fill_core_i;
  logic        cev_valid_i;
  logic [11:0] cev_addr_i;
  logic [1:0]  cev_core_i;
  logic        lkp_done_o, lkp_hit_o, binv_valid_o;
  logic [3:0]  lkp_snoop_o, binv_mask_o;
  logic [11:0] binv_addr_o;

  always #5 clk = ~clk;

  cv_tracker dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .lkp_valid_i(lkp_valid_i), .lkp_write_i(lkp_write_i),
    .lkp_addr_i(lkp_addr_i), .lkp_core_i(lkp_core_i),
    .fill_valid_i(fill_valid_i), .fill_drop_i(fill_drop_i),
    .fill_addr_i(fill_addr_i), .fill_core_i(fill_core_i),
    .cev_valid_i(cev_valid_i), .cev_addr_i(cev_addr_i), .cev_core_i(cev_core_i),
    .lkp_done_o(lkp_done_o), .lkp_hit_o(lkp_hit_o), .lkp_snoop_o(lkp_snoop_o),
    .binv_valid_o(binv_valid_o), .binv_addr_o(binv_addr_o), .binv_mask_o(binv_mask_o)
  );

  typedef struct packed {
    logic        done;
    logic        hit;
    logic [3:0]  snoop;
    logic        binv;
    logic [11:0] baddr;
    logic [3:0]  bmask;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    n_chk = 0;
  int    n_bad = 0;
  exp_t  got, want;
  string cur;

  function automatic exp_t mk(input logic d, input logic h, input logic [3:0] s,
                              input logic b, input logic [11:0] ba, input logic [3:0] bm);
    exp_t e;
    e.done = d; e.hit = h; e.snoop = s; e.binv = b; e.baddr = ba; e.bmask = bm;
    return e;
  endfunction

  task automatic check_now(input exp_t e, input string t);
    got = {lkp_done_o, lkp_hit_o, lkp_snoop_o, binv_valid_o, binv_addr_o, binv_mask_o};
    n_chk++;
    if (got !== e) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", t, got, e);
    end
  endtask

  // monitor: result of the op driven at the previous negedge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        want = exp_q.pop_front();
        cur  = tag_q.pop_front();
        check_now(want, cur);
      end
    end
  end

  task automatic drive(input logic fv, input logic fd, input logic [11:0] fa, input logic [1:0] fc,
                       input logic lv, input logic lw, input logic [11:0] la, input logic [1:0] lc,
                       input logic cv, input logic [11:0] ca, input logic [1:0] cc,
                       input exp_t e, input string t);
    @(negedge clk);
    fill_valid_i = fv; fill_drop_i = fd; fill_addr_i = fa; fill_core_i = fc;
    lkp_valid_i = lv; lkp_write_i = lw; lkp_addr_i = la; lkp_core_i = lc;
    cev_valid_i = cv; cev_addr_i = ca; cev_core_i = cc;
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  task automatic lookup(input logic [11:0] a, input logic [1:0] c, input logic w,
                        input logic h, input logic [3:0] s, input string t);
    drive(0, 0, 0, 0, 1, w, a, c, 0, 0, 0, mk(1, h, s, 0, 0, 0), t);
  endtask

  task automatic fill(input logic [11:0] a, input logic [1:0] c, input logic b,
                      input logic [11:0] ba, input logic [3:0] bm, input string t);
    drive(1, 0, a, c, 0, 0, 0, 0, 0, 0, 0, mk(0, 0, 0, b, ba, bm), t);
  endtask

  task automatic drop(input logic [11:0] a, input logic b, input logic [3:0] bm, input string t);
    drive(1, 1, a, 0, 0, 0, 0, 0, 0, 0, 0, mk(0, 0, 0, b, b ? a : 12'h0, bm), t);
  endtask

  task automatic notify(input logic [11:0] a, input logic [1:0] c, input string t);
    drive(0, 0, 0, 0, 0, 0, 0, 0, 1, a, c, mk(0, 0, 0, 0, 0, 0), t);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_ni = 1'b0;
    fill_valid_i = 0; fill_drop_i = 0; fill_addr_i = 0; fill_core_i = 0;
    lkp_valid_i = 0; lkp_write_i = 0; lkp_addr_i = 0; lkp_core_i = 0;
    cev_valid_i = 0; cev_addr_i = 0; cev_core_i = 0;
    repeat (3) @(negedge clk);
    check_now(mk(0, 0, 0, 0, 0, 0), "R1 outputs in reset");
    rst_ni = 1'b1;
    @(negedge clk);
    check_now(mk(0, 0, 0, 0, 0, 0), "R1 outputs after reset");

    lookup(12'h013, 0, 0, 0, 4'b0000, "R1 R3 first read misses");
    lookup(12'h013, 1, 0, 0, 4'b0000, "R3 miss did not allocate");
    fill  (12'h013, 0, 0, 0, 0,       "R6 fill empty set");
    lookup(12'h013, 1, 0, 1, 4'b0001, "R4 read hit one holder");
    lookup(12'h013, 2, 0, 1, 4'b0011, "R4 read hit two holders");
    lookup(12'h013, 0, 0, 1, 4'b0110, "R4 requester excluded");
    lookup(12'h013, 3, 1, 1, 4'b0111, "R5 write hit snoops others");
    lookup(12'h013, 0, 0, 1, 4'b1000, "R5 only writer remains");
    notify(12'h013, 3,                "R9 notice produces nothing");
    lookup(12'h013, 1, 1, 1, 4'b0001, "R9 notice cleared core3 bit");
    notify(12'h023, 1,                "R9 absent notice quiet");
    lookup(12'h013, 0, 0, 1, 4'b0010, "R9 R11 absent notice no effect");
    fill  (12'h013, 2, 0, 0, 0,       "R6 fill resident line no binv");
    lookup(12'h013, 3, 0, 1, 4'b0111, "R6 fill merged core2 bit");
    fill  (12'h023, 1, 1, 12'h013, 4'b1111, "R7 R11 conflict fill evicts");
    lookup(12'h013, 0, 0, 0, 4'b0000, "R11 victim gone");
    lookup(12'h023, 0, 0, 1, 4'b0010, "R6 replacing fill only filler bit");
    drop  (12'h033, 0, 4'b0000,       "R8 drop absent quiet");
    drop  (12'h023, 1, 4'b0011,       "R8 drop resident binv");
    lookup(12'h023, 1, 0, 0, 4'b0000, "R8 dropped line misses");
    lookup(12'h099, 0, 1, 0, 4'b0000, "R3 write miss");
    // fill, lookup and notice together: only the fill is taken
    drive(1, 0, 12'h045, 2, 1, 0, 12'h045, 0, 1, 12'h045, 2,
          mk(0, 0, 0, 0, 0, 0), "R10 fill beats lookup and notice");
    lookup(12'h045, 0, 0, 1, 4'b0100, "R10 notice was discarded");
    // lookup and notice together: only the lookup is taken
    drive(0, 0, 0, 0, 1, 0, 12'h045, 1, 1, 12'h045, 2,
          mk(1, 1, 4'b0101, 0, 0, 0), "R10 lookup beats notice");
    lookup(12'h045, 3, 0, 1, 4'b0111, "R10 core2 bit kept");
    fill  (12'h0a5, 3, 1, 12'h045, 4'b1111, "R7 victim full vector");
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, mk(0, 0, 0, 0, 0, 0), "R2 idle quiet");
    repeat (2) @(negedge clk);
    n_chk++;
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R2 pending results got=%0d exp=0", exp_q.size());
    end
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule